// File: doc/BRIEF.md
# Decimated Preamble Auto-Correlator and Packet Detector

This block sits at the front of a multiband OFDM receiver. It takes complex baseband samples four per clock and watches for a preamble whose symbol repeats every 165 samples. A full-rate delayed auto-correlator would need four multipliers and 165 stored samples. This one uses a single complex multiply per clock and keeps a 41-entry history. Each clock it pairs one sample of the current clock with the sample exactly 165 positions earlier, which sits in a different lane 41 clocks back. So only one sample in four takes part in the correlation.

Products and current-sample powers are summed over windows of 41 accepted clocks. At the end of each window the complex correlation and the power sum appear at the outputs for one cycle. A downstream frequency-offset estimator can take the correlation's phase. Timing logic can use its sign. The same window result feeds a packet-detect comparison against a programmable threshold. The comparison squares both sides, so no divider or square root is needed. The detect flag holds until a restart or reset.

Top module: `pa_corr_det`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `det` and `corr_valid` are 0.
- R2: Lane l of a clock occupies bits [5l+4:5l] of `in_i` (real) and `in_q` (imaginary), as 5-bit two's complement values; the sample index within the stream is 4·clock+l. On every accepted clock (`in_valid` high), the product is the lane-1 sample multiplied by the complex conjugate of the lane-0 sample accepted 41 clocks earlier, a lag of 165 samples. Lanes 2 and 3 have no effect on any output.
- R3: Products are summed in windows of 41 accepted clocks, and the first window starts once 41 clocks have filled the history. The first `corr_valid` pulse therefore appears in the clock after the 82nd accepted input clock since reset or restart. `corr_re`/`corr_im` then carry the sum.
- R4: `pwr` carries the sum of I² + Q² of the lane-1 samples used in the same window, valid with `corr_valid`.
- R5: In the clock after a `corr_valid` pulse, `det` becomes 1 when (corr_re² + corr_im²)·64 is strictly greater than `thr`·pwr². `thr` is unsigned and has 6 fractional bits.
- R6: Once set, `det` stays 1 whatever follows, until `restart` or `rst`.
- R7: A `restart` clock clears `det`, `corr_valid`, the history fill and the running window. In the next clock both outputs are 0, and the timing of R3 counts again from that restart.
- R8: A clock with `in_valid` low changes no history, count or sum. Gaps in the input therefore give the same correlation, power and detect result as a gap-free stream.
- R9: With every sample at full scale (−16, −16), a window gives corr_re = pwr = 20992 and corr_im = 0, with no wrap.
- R10: `corr_valid` is a one-cycle pulse and repeats every 41 accepted clocks: 130 accepted clocks after a restart yield exactly two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Clears detect and restarts history fill and windowing |
| in_valid | input | 1 | The four lanes of this clock are to be accepted |
| in_i | input | 20 | Real parts of the four lanes, lane l at bits [5l+4:5l] |
| in_q | input | 20 | Imaginary parts of the four lanes, same packing |
| thr | input | 8 | Detect threshold, unsigned with 6 fractional bits |
| corr_valid | output | 1 | One-cycle strobe marking a finished window |
| corr_re | output | 17 | Real part of the window correlation, signed |
| corr_im | output | 17 | Imaginary part of the window correlation, signed |
| pwr | output | 16 | Window power sum, unsigned |
| det | output | 1 | Sticky packet-detect flag |

## Verification
The assertions take for granted that `restart` is a short pulse during which `in_valid` is low. They also assume `thr` changes only around a restart, so that a window is never compared against a threshold that moved in the middle of it. The stimulus follows these rules: it sets `thr` before each restart pulse and holds `in_valid` low during it. It drives lane values only within the 5-bit signed range, and it negates values only within −15..15, so sign inversion never overflows.

// File: rtl/pa_pkg.sv
package pa_pkg;
    // Stream geometry
    localparam int LANES     = 4;
    localparam int SMP_W     = 5;
    localparam int SYM_LEN   = 165;
    // Threshold format
    localparam int TH_W      = 8;
    localparam int TH_FRAC   = 6;
    // Decimated history: one lane stored per clock
    localparam int DLY_LANE  = 0;
    localparam int DLY_DEPTH = SYM_LEN / LANES;
    localparam int CUR_LANE  = DLY_LANE + (SYM_LEN % LANES);
    localparam int ACC_LEN   = DLY_DEPTH;
    localparam int LOG_ACC   = $clog2(ACC_LEN);
    // Datapath widths
    localparam int IN_W      = LANES * SMP_W;
    localparam int PROD_W    = 2 * SMP_W + 1;
    localparam int POW_W     = 2 * SMP_W;
    localparam int ACC_W     = PROD_W + LOG_ACC;
    localparam int PWR_W     = POW_W + LOG_ACC;
    localparam int CMP_W     = 2 * ACC_W + TH_W;
endpackage

// File: rtl/pa_dline.sv
module pa_dline #(
    parameter int W     = 10,
    parameter int DEPTH = 41
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] taps;
        logic [CW-1:0]           fill;
    } dl_state_t;

    dl_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift) begin
            s_d.taps[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                s_d.taps[i] = s_q.taps[i-1];
            end
            if (s_q.fill != CW'(DEPTH)) begin
                s_d.fill = s_q.fill + CW'(1);
            end
        end
        if (flush) begin
            s_d.fill = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.taps[DEPTH-1];
    assign full = (s_q.fill == CW'(DEPTH));
endmodule

// File: rtl/pa_cmac.sv
module pa_cmac #(
    parameter int SMP_W  = 5,
    parameter int PROD_W = 11,
    parameter int POW_W  = 10
) (
    input  logic signed [SMP_W-1:0]  cur_re,
    input  logic signed [SMP_W-1:0]  cur_im,
    input  logic signed [SMP_W-1:0]  old_re,
    input  logic signed [SMP_W-1:0]  old_im,
    output logic signed [PROD_W-1:0] prod_re,
    output logic signed [PROD_W-1:0] prod_im,
    output logic [POW_W-1:0]         pow
);
    logic signed [PROD_W-1:0] cr_x, ci_x, or_x, oi_x;
    logic signed [PROD_W-1:0] pow_x;

    always_comb begin
        cr_x    = cur_re;
        ci_x    = cur_im;
        or_x    = old_re;
        oi_x    = old_im;
        // current times conjugate of the older sample
        prod_re = cr_x * or_x + ci_x * oi_x;
        prod_im = ci_x * or_x - cr_x * oi_x;
        pow_x   = cr_x * cr_x + ci_x * ci_x;
        pow     = POW_W'($unsigned(pow_x));
    end
endmodule

// File: rtl/pa_window.sv
module pa_window #(
    parameter int PROD_W  = 11,
    parameter int POW_W   = 10,
    parameter int ACC_LEN = 41,
    parameter int ACC_W   = 17,
    parameter int PWR_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     take,
    input  logic signed [PROD_W-1:0] prod_re,
    input  logic signed [PROD_W-1:0] prod_im,
    input  logic [POW_W-1:0]         pow,
    output logic                     out_vld,
    output logic signed [ACC_W-1:0]  out_re,
    output logic signed [ACC_W-1:0]  out_im,
    output logic [PWR_W-1:0]         out_pw
);
    localparam int CNT_W = $clog2(ACC_LEN);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc_re;
        logic signed [ACC_W-1:0] acc_im;
        logic [PWR_W-1:0]        acc_pw;
        logic [CNT_W-1:0]        cnt;
        logic signed [ACC_W-1:0] res_re;
        logic signed [ACC_W-1:0] res_im;
        logic [PWR_W-1:0]        res_pw;
        logic                    res_vld;
    } win_state_t;

    win_state_t s_d, s_q;
    logic signed [ACC_W-1:0] sum_re, sum_im;
    logic [PWR_W-1:0]        sum_pw;

    always_comb begin
        s_d         = s_q;
        s_d.res_vld = 1'b0;
        sum_re      = s_q.acc_re + ACC_W'(prod_re);
        sum_im      = s_q.acc_im + ACC_W'(prod_im);
        sum_pw      = s_q.acc_pw + PWR_W'(pow);
        if (flush) begin
            s_d.acc_re = '0;
            s_d.acc_im = '0;
            s_d.acc_pw = '0;
            s_d.cnt    = '0;
        end else if (take) begin
            if (s_q.cnt == CNT_W'(ACC_LEN - 1)) begin
                s_d.res_re  = sum_re;
                s_d.res_im  = sum_im;
                s_d.res_pw  = sum_pw;
                s_d.res_vld = 1'b1;
                s_d.acc_re  = '0;
                s_d.acc_im  = '0;
                s_d.acc_pw  = '0;
                s_d.cnt     = '0;
            end else begin
                s_d.acc_re = sum_re;
                s_d.acc_im = sum_im;
                s_d.acc_pw = sum_pw;
                s_d.cnt    = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_vld = s_q.res_vld;
    assign out_re  = s_q.res_re;
    assign out_im  = s_q.res_im;
    assign out_pw  = s_q.res_pw;
endmodule

// File: rtl/pa_detect.sv
module pa_detect #(
    parameter int ACC_W   = 17,
    parameter int PWR_W   = 16,
    parameter int TH_W    = 8,
    parameter int TH_FRAC = 6,
    parameter int CMP_W   = 42
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    vld,
    input  logic signed [ACC_W-1:0] c_re,
    input  logic signed [ACC_W-1:0] c_im,
    input  logic [PWR_W-1:0]        pw,
    input  logic [TH_W-1:0]         thr,
    output logic                    det
);
    typedef struct packed {
        logic hit;
    } det_state_t;

    det_state_t s_d, s_q;
    logic signed [CMP_W-1:0] re_x, im_x;
    logic [CMP_W-1:0]        mag, lhs, rhs, pw_x, th_x;

    always_comb begin
        re_x = CMP_W'(c_re);
        im_x = CMP_W'(c_im);
        pw_x = CMP_W'(pw);
        th_x = CMP_W'(thr);
        mag  = $unsigned(re_x * re_x + im_x * im_x);
        lhs  = mag << TH_FRAC;
        rhs  = th_x * pw_x * pw_x;
        s_d  = s_q;
        if (vld && (lhs > rhs)) begin
            s_d.hit = 1'b1;
        end
        if (flush) begin
            s_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign det = s_q.hit;
endmodule

// File: rtl/pa_corr_det.sv
module pa_corr_det
    import pa_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restart,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_i,
    input  logic [IN_W-1:0]         in_q,
    input  logic [TH_W-1:0]         thr,
    output logic                    corr_valid,
    output logic signed [ACC_W-1:0] corr_re,
    output logic signed [ACC_W-1:0] corr_im,
    output logic [PWR_W-1:0]        pwr,
    output logic                    det
);
    localparam logic [IN_W-1:0] LANE_ONES = IN_W'({SMP_W{1'b1}});
    localparam logic [IN_W-1:0] USED_MASK =
        (LANE_ONES << (CUR_LANE * SMP_W)) | (LANE_ONES << (DLY_LANE * SMP_W));

    logic signed [SMP_W-1:0] lane_re [LANES];
    logic signed [SMP_W-1:0] lane_im [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_re[l] = in_i[l*SMP_W +: SMP_W];
        assign lane_im[l] = in_q[l*SMP_W +: SMP_W];
    end

    // lanes outside the decimated group are deliberately dropped
    logic unused_lanes;
    assign unused_lanes = (^(in_i & ~USED_MASK)) ^ (^(in_q & ~USED_MASK));

    logic [2*SMP_W-1:0]       dl_in, dl_out;
    logic                     dl_full;
    logic signed [SMP_W-1:0]  old_re, old_im;
    logic signed [PROD_W-1:0] p_re, p_im;
    logic [POW_W-1:0]         p_pow;
    logic                     take;

    assign dl_in  = {lane_re[DLY_LANE], lane_im[DLY_LANE]};
    assign old_re = dl_out[2*SMP_W-1:SMP_W];
    assign old_im = dl_out[SMP_W-1:0];
    assign take   = in_valid & dl_full;

    pa_dline #(
        .W    (2 * SMP_W),
        .DEPTH(DLY_DEPTH)
    ) dline_i (
        .clk  (clk),
        .rst  (rst),
        .flush(restart),
        .shift(in_valid),
        .din  (dl_in),
        .dout (dl_out),
        .full (dl_full)
    );

    pa_cmac #(
        .SMP_W (SMP_W),
        .PROD_W(PROD_W),
        .POW_W (POW_W)
    ) cmac_i (
        .cur_re (lane_re[CUR_LANE]),
        .cur_im (lane_im[CUR_LANE]),
        .old_re (old_re),
        .old_im (old_im),
        .prod_re(p_re),
        .prod_im(p_im),
        .pow    (p_pow)
    );

    pa_window #(
        .PROD_W (PROD_W),
        .POW_W  (POW_W),
        .ACC_LEN(ACC_LEN),
        .ACC_W  (ACC_W),
        .PWR_W  (PWR_W)
    ) win_i (
        .clk    (clk),
        .rst    (rst),
        .flush  (restart),
        .take   (take),
        .prod_re(p_re),
        .prod_im(p_im),
        .pow    (p_pow),
        .out_vld(corr_valid),
        .out_re (corr_re),
        .out_im (corr_im),
        .out_pw (pwr)
    );

    pa_detect #(
        .ACC_W  (ACC_W),
        .PWR_W  (PWR_W),
        .TH_W   (TH_W),
        .TH_FRAC(TH_FRAC),
        .CMP_W  (CMP_W)
    ) det_i (
        .clk  (clk),
        .rst  (rst),
        .flush(restart),
        .vld  (corr_valid),
        .c_re (corr_re),
        .c_im (corr_im),
        .pw   (pwr),
        .thr  (thr),
        .det  (det)
    );
endmodule

// File: rtl/pa_corr_det_chk.sv
module pa_corr_det_chk (
    input logic clk,
    input logic rst,
    input logic restart,
    input logic in_valid,
    input logic corr_valid,
    input logic det
);
    // R10
    corr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        corr_valid |=> !corr_valid);

    // R6
    det_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (det && !restart) |=> det);

    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!det && !corr_valid));

    // R5
    det_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(det) |-> $past(corr_valid));

    // R8
    window_take_chk: assert property (@(posedge clk) disable iff (rst)
        corr_valid |-> $past(in_valid && !restart));
endmodule

bind pa_corr_det pa_corr_det_chk chk_i (.*);

// File: tb/pa_corr_det_tb_top.sv
module pa_corr_det_tb_top;
    logic        clk = 1'b0;
    logic        rst, restart, in_valid;
    logic [19:0] in_i, in_q;
    logic [7:0]  thr;
    logic        corr_valid, det;
    logic signed [16:0] corr_re, corr_im;
    logic [15:0] pwr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pa_corr_det dut_i (
        .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .thr(thr),
        .corr_valid(corr_valid), .corr_re(corr_re), .corr_im(corr_im),
        .pwr(pwr), .det(det)
    );

    // pattern: 0 zero, 1 periodic, 2 sign-flipped each period, 3 noise, 4 full scale
    // exp_det: 0/1 fixed by R5 analysis, 2 = taken from the window model
    localparam int N_ROWS = 10;
    localparam int T_PAT [N_ROWS] = '{1, 1, 1, 1, 2, 3, 0, 4, 1, 3};
    localparam int T_THR [N_ROWS] = '{0, 32, 63, 64, 32, 32, 0, 255, 32, 0};
    localparam int T_GAP [N_ROWS] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
    localparam int T_DET [N_ROWS] = '{1, 1, 1, 0, 1, 2, 0, 0, 1, 2};

    task automatic chk(string req, longint act, longint exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int noise(int n, int sh);
        logic [31:0] h;
        h = 32'(n) * 32'd1103515245 + 32'd12345;
        h = h ^ (h >> 13);
        return int'((h >> sh) & 32'd31) - 16;
    endfunction

    function automatic int smp(int pat, int n, bit imag);
        int m, v;
        m = n % 165;
        case (pat)
            1, 2: begin
                v = imag ? ((m * 13 + 5) % 31) - 15 : ((m * 7 + 3) % 31) - 15;
                if (pat == 2 && ((n / 165) % 2) == 1) v = -v;
            end
            3: v = imag ? noise(n, 9) : noise(n, 3);
            4: v = -16;
            default: v = 0;
        endcase
        return v;
    endfunction

    task automatic drive_lanes(int pat, int vk);
        for (int l = 0; l < 4; l++) begin
            int n, vi, vq;
            n = 4 * vk + l;
            if (l < 2) begin
                vi = smp(pat, n, 1'b0);
                vq = smp(pat, n, 1'b1);
            end else begin
                vi = noise(n + 999, 3);
                vq = noise(n + 999, 9);
            end
            in_i[l*5 +: 5] = 5'(vi);
            in_q[l*5 +: 5] = 5'(vq);
        end
    endtask

    // first window: lane-1 sample of clock k against lane-0 sample of clock k-41
    task automatic model(input int pat, input int th, output longint mre,
                         output longint mim, output longint mpw, output int mdet);
        mre = 0; mim = 0; mpw = 0;
        for (int k = 41; k <= 81; k++) begin
            longint ci, cq, di, dq;
            ci = smp(pat, 4 * k + 1, 1'b0);
            cq = smp(pat, 4 * k + 1, 1'b1);
            di = smp(pat, 4 * k - 164, 1'b0);
            dq = smp(pat, 4 * k - 164, 1'b1);
            mre += ci * di + cq * dq;
            mim += cq * di - ci * dq;
            mpw += ci * ci + cq * cq;
        end
        mdet = ((mre * mre + mim * mim) * 64 > longint'(th) * mpw * mpw) ? 1 : 0;
    endtask

    task automatic do_restart();
        restart  = 1'b1;
        in_valid = 1'b0;
        @(posedge clk); #1;
        restart = 1'b0;
        chk("R7", det, 0, "det after restart");
        chk("R7", corr_valid, 0, "corr_valid after restart");
    endtask

    task automatic run_row(int r);
        int pat, vk, first_cv, exp_cv, pulses, det_first, mdet, edet;
        longint mre, mim, mpw, cre, cim, cpw;
        string rq;
        pat = T_PAT[r];
        thr = 8'(T_THR[r]);
        do_restart();
        vk = 0; first_cv = -1; exp_cv = -2; pulses = 0; det_first = -1;
        cre = 0; cim = 0; cpw = 0;
        for (int it = 0; vk < 130; it++) begin
            bit v;
            int vnow;
            v = !(T_GAP[r] == 1 && (it % 3) == 2);
            in_valid = v;
            vnow = vk;
            if (v) drive_lanes(pat, vk);
            else begin in_i = 20'hABCDE; in_q = 20'h13579; end
            @(posedge clk); #1;
            if (v) vk++;
            if (first_cv >= 0 && it == first_cv + 1) det_first = det;
            if (corr_valid) begin
                pulses++;
                if (first_cv < 0) begin
                    first_cv = it;
                    cre = corr_re; cim = corr_im; cpw = pwr;
                end
            end
            if (v && vnow == 81) exp_cv = it;
        end
        in_valid = 1'b0;
        model(pat, T_THR[r], mre, mim, mpw, mdet);
        edet = (T_DET[r] == 2) ? mdet : T_DET[r];
        rq = (pat == 4) ? "R9" : "R2";
        chk("R3", first_cv, exp_cv, "first corr_valid clock");
        chk(rq, cre, mre, "corr_re");
        chk(rq, cim, mim, "corr_im");
        chk((pat == 4) ? "R9" : "R4", cpw, mpw, "pwr");
        chk("R5", det_first, edet, "det after first window");
        chk("R10", pulses, 2, "corr_valid pulses in 130 clocks");
        if (T_GAP[r] == 1) chk("R8", cre + cim + cpw, mre + mim + mpw, "gapped stream sum");
    endtask

    initial begin
        rst = 1'b1; restart = 1'b0; in_valid = 1'b0;
        in_i = '0; in_q = '0; thr = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R1", det, 0, "det after reset");
        chk("R1", corr_valid, 0, "corr_valid after reset");

        for (int r = 0; r < N_ROWS; r++) run_row(r);

        // sticky flag: detect, then feed silence for several windows
        run_row(1);
        for (int c = 0; c < 100; c++) begin
            in_valid = 1'b1;
            in_i = '0; in_q = '0;
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        chk("R6", det, 1, "det held over silent windows");

        // reset in mid-stream clears the flag
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        chk("R1", det, 0, "det after mid-run reset");
        chk("R1", corr_valid, 0, "corr_valid after mid-run reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule